// File: doc/BRIEF.md
# Downstream Port Line-State Monitor

This block watches the two data lines of one downstream hub port, sampled as already synchronized logic levels, and works out what the attached device is doing. An idle port with nothing plugged in shows both lines low. A device announces itself by pulling exactly one line high. A high D+ means the device runs at full speed, and a high D- means it runs at low speed. Once the pattern has held for a debounce interval, the port is marked connected and the speed is latched. A disconnect needs both lines low for longer than a programmable threshold, so a normal two-bit end-of-packet never triggers it.

The monitor also classifies every cycle as J, K, SE0 or SE1. The J and K polarity follows the latched speed. While the port is connected, an unbroken run of J cycles lasting the suspend interval (3 ms at the real clock, given in cycles) raises the suspend flag. Any other line state clears the flag and restarts the timer. Both lines high is illegal and is flagged on its own output.

Top module: `hub_port_line_monitor`

## Requirements
- R1: While reset is applied, and on the first cycles after it, connected, full_speed and suspend are all 0.
- R2: line_state is combinational from the inputs: 2'b00 = SE0 (both lines low), 2'b11 = SE1 (both lines high), 2'b01 = J, 2'b10 = K. J is D+ high with D- low when connected at full speed or when disconnected, and D+ low with D- high when connected at low speed. K is the opposite differential pattern.
- R3: A disconnected port becomes connected only after one line alone has been high, with the same line high, for more than DEBOUNCE_CYC consecutive cycles. A shorter pulse leaves it disconnected.
- R4: At attach, full_speed is set to 1 if D+ was the high line and to 0 if D- was.
- R5: A connected port becomes disconnected after DISC_CYC consecutive SE0 cycles. A shorter SE0, such as an end-of-packet, keeps it connected.
- R6: While connected, suspend rises after SUSPEND_CYC consecutive J cycles.
- R7: Any cycle with a line state other than J clears suspend on the next clock edge and restarts the idle count.
- R8: illegal_se1 is 1 exactly when both lines are high.
- R9: full_speed holds its value while the port stays connected. A detach followed by a reattach at the other speed updates it.
- R10: suspend is never 1 while the port is disconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dp | input | 1 | Synchronized D+ level |
| dm | input | 1 | Synchronized D- level |
| connected | output | 1 | A device is attached |
| full_speed | output | 1 | 1 = full-speed device, 0 = low-speed device |
| line_state | output | 2 | 00 SE0, 01 J, 10 K, 11 SE1 |
| illegal_se1 | output | 1 | Both lines high |
| suspend | output | 1 | Bus idle (J) for the suspend interval while connected |

## Verification
The assertions check the following on every cycle:
- A connect is always preceded by a single-line-high sample.
- A disconnect is always preceded by SE0.
- The speed stays fixed while the port is connected.
- Suspend appears only while the port is connected and only after J.
- Suspend drops one edge after any non-J cycle.

The debounce lengths, the boundary between a short SE0 and a real detach, the speed-dependent J/K polarity and the reattach at the other speed are shown only by the bench's scenarios.

// File: rtl/hpl_pkg.sv
package hpl_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;
endpackage

// File: rtl/hpl_line_decode.sv
module hpl_line_decode
  import hpl_pkg::*;
(
  input  logic  dp,
  input  logic  dm,
  input  logic  low_speed,
  output line_t ls
);
  always_comb begin
    if (!dp && !dm)     ls = LS_SE0;
    else if (dp && dm)  ls = LS_SE1;
    else if (dp ^ low_speed) ls = LS_J;
    else                ls = LS_K;
  end
endmodule

// File: rtl/hpl_attach_ctl.sv
module hpl_attach_ctl #(
  parameter int DEBOUNCE_CYC = 25000,
  parameter int DISC_CYC     = 625
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic dp,
  input  logic dm,
  output logic connected,
  output logic full_speed
);
  localparam int MAXC = (DEBOUNCE_CYC > DISC_CYC) ? DEBOUNCE_CYC : DISC_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DEB_LAST  = CW'(DEBOUNCE_CYC - 1);
  localparam logic [CW-1:0] DISC_LAST = CW'(DISC_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          conn_q, conn_d, fs_q, fs_d;
  logic          prev_dp_q, prev_valid_q;
  logic          valid, same, se0;

  always_comb begin
    valid  = dp ^ dm;
    same   = valid && prev_valid_q && (dp == prev_dp_q);
    se0    = !dp && !dm;
    cnt_d  = cnt_q;
    conn_d = conn_q;
    fs_d   = fs_q;
    if (!conn_q) begin
      if (same) begin
        if (cnt_q >= DEB_LAST) begin
          conn_d = 1'b1;
          fs_d   = dp;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end else begin
      if (se0) begin
        if (cnt_q >= DISC_LAST) begin
          conn_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      conn_q       <= 1'b0;
      fs_q         <= 1'b0;
      prev_dp_q    <= 1'b0;
      prev_valid_q <= 1'b0;
    end else begin
      cnt_q        <= cnt_d;
      conn_q       <= conn_d;
      fs_q         <= fs_d;
      prev_dp_q    <= dp;
      prev_valid_q <= valid;
    end
  end

  assign connected  = conn_q;
  assign full_speed = fs_q;

  // R3
  attach_needs_single_high_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(conn_q) |-> $past(dp ^ dm));
  // R5
  detach_needs_se0_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(conn_q) |-> $past(!dp && !dm));
  // R9
  speed_held_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (conn_q && $past(conn_q)) |-> $stable(fs_q));
endmodule

// File: rtl/hpl_idle_timer.sv
module hpl_idle_timer #(
  parameter int SUSPEND_CYC = 750000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic connected,
  input  logic is_j,
  output logic suspend
);
  localparam int CW = $clog2(SUSPEND_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SUSPEND_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          susp_q, susp_d;
  logic          idle_now;

  always_comb begin
    idle_now = connected && is_j;
    if (!idle_now)         cnt_d = '0;
    else if (cnt_q < LAST) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
    susp_d = idle_now && (cnt_q >= LAST);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      susp_q <= susp_d;
    end
  end

  assign suspend = susp_q;

  // R10
  suspend_only_connected_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    susp_q |-> connected);
  // R7
  activity_clears_suspend_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !is_j |=> !susp_q);
  // R6
  suspend_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(susp_q) |-> $past(is_j));
endmodule

// File: rtl/hub_port_line_monitor.sv
module hub_port_line_monitor
  import hpl_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 25000,
  parameter int DISC_CYC     = 625,
  parameter int SUSPEND_CYC  = 750000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp,
  input  logic       dm,
  output logic       connected,
  output logic       full_speed,
  output logic [1:0] line_state,
  output logic       illegal_se1,
  output logic       suspend
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  line_t      ls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  hpl_attach_ctl #(.DEBOUNCE_CYC(DEBOUNCE_CYC), .DISC_CYC(DISC_CYC)) u_attach (
    .clk(clk), .rst_ni(rst_ni), .dp(dp), .dm(dm),
    .connected(connected), .full_speed(full_speed)
  );

  hpl_line_decode u_decode (
    .dp(dp), .dm(dm), .low_speed(connected && !full_speed), .ls(ls)
  );

  hpl_idle_timer #(.SUSPEND_CYC(SUSPEND_CYC)) u_idle (
    .clk(clk), .rst_ni(rst_ni), .connected(connected),
    .is_j(ls == LS_J), .suspend(suspend)
  );

  assign line_state  = ls;
  assign illegal_se1 = (ls == LS_SE1);
endmodule

// File: tb/hub_port_line_monitor_test.sv
`timescale 1ns/1ps
module hub_port_line_monitor_test;
  localparam int DEB = 8, DISC = 20, SUSP = 40;
  localparam int NV = 15;
  // {dp, dm, hold[7:0], conn, fs, chk_fs, ls[1:0], susp}
  localparam logic [15:0] VEC [NV] = '{
    {2'b00, 8'd5,  1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R1/R2 idle SE0
    {2'b10, 8'd4,  1'b0, 1'b0, 1'b0, 2'b01, 1'b0}, // R3 short pulse
    {2'b00, 8'd3,  1'b0, 1'b0, 1'b0, 2'b00, 1'b0},
    {2'b10, 8'd12, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0}, // R3/R4 full-speed attach
    {2'b10, 8'd45, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1}, // R6
    {2'b01, 8'd1,  1'b1, 1'b1, 1'b1, 2'b10, 1'b0}, // R7 K clears
    {2'b00, 8'd2,  1'b1, 1'b1, 1'b1, 2'b00, 1'b0}, // R5 EOP keeps link
    {2'b10, 8'd10, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0},
    {2'b11, 8'd1,  1'b1, 1'b1, 1'b1, 2'b11, 1'b0}, // R8 SE1
    {2'b00, 8'd25, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R5/R10 detach
    {2'b01, 8'd12, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0}, // R4/R9 low-speed attach
    {2'b10, 8'd3,  1'b1, 1'b0, 1'b1, 2'b10, 1'b0}, // R2 low-speed K
    {2'b01, 8'd45, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1}, // R6 low speed
    {2'b00, 8'd15, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0}, // R5 short SE0
    {2'b00, 8'd10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}  // R5 threshold crossed
  };

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b0;
  logic connected, full_speed, illegal_se1, suspend;
  logic [1:0] line_state;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  hub_port_line_monitor #(.DEBOUNCE_CYC(DEB), .DISC_CYC(DISC), .SUSPEND_CYC(SUSP)) uut (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .connected(connected),
    .full_speed(full_speed), .line_state(line_state),
    .illegal_se1(illegal_se1), .suspend(suspend)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic p, input logic m, input int hold);
    @(negedge clk);
    dp = p; dm = m;
    repeat (hold) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 connected in reset", {1'b0, connected}, 2'd0);
    check("R1 suspend in reset", {1'b0, suspend}, 2'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 connected after reset", {1'b0, connected}, 2'd0);
    check("R1 full_speed after reset", {1'b0, full_speed}, 2'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15], VEC[i][14], int'(VEC[i][13:6]));
      check($sformatf("R3/R5 connected v%0d", i), {1'b0, connected}, {1'b0, VEC[i][5]});
      if (VEC[i][3])
        check($sformatf("R4/R9 full_speed v%0d", i), {1'b0, full_speed}, {1'b0, VEC[i][4]});
      check($sformatf("R2 line_state v%0d", i), line_state, VEC[i][2:1]);
      check($sformatf("R6/R7/R10 suspend v%0d", i), {1'b0, suspend}, {1'b0, VEC[i][0]});
      check($sformatf("R8 illegal_se1 v%0d", i), {1'b0, illegal_se1},
            {1'b0, VEC[i][2:1] == 2'b11});
    end

    // R1: reset from a connected, suspended port
    apply(1'b1, 1'b0, 60);
    check("R6 suspend before reset", {1'b0, suspend}, 2'd1);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 connected cleared by reset", {1'b0, connected}, 2'd0);
    check("R1 suspend cleared by reset", {1'b0, suspend}, 2'd0);
    check("R1 full_speed cleared by reset", {1'b0, full_speed}, 2'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 1'b0, 5);
    check("R3 no connect before debounce", {1'b0, connected}, 2'd0);
    apply(1'b1, 1'b0, 10);
    check("R3 reconnect after reset", {1'b0, connected}, 2'd1);
    check("R4 reconnect full speed", {1'b0, full_speed}, 2'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule